// File: doc/BRIEF.md
# Return Address Register Unit with Stack Spill

This unit keeps a 22-bit program counter together with a single return address register. A fast call and a fast return move control in one cycle: the program counter takes its new value in the cycle the command is accepted. The return address register is kept in step with a stack in memory. Each fast call saves the register's previous contents on the stack, and each fast return reloads the register from it. Both moves go through a 16-bit memory port, so each takes two word transfers.

The stack pointer counts in 16-bit words and is held inside the unit. A simple request/acknowledge memory port carries each transfer. The unit raises `busy` until both transfers of a fast call or return have finished, and it ignores new commands while busy. A plain jump command loads the program counter and leaves the return register and the stack alone. It stands for every control transfer that does not use the fast scheme.

Top module: `linkspill_unit`

## Requirements
- R1: While reset is low and after it rises, `pc`, `linkReg` and `sp` equal the parameters `PC_RST`, `LINK_RST` and `SP_RST`, and `busy` and `memReq` are low.
- R2: When `callReq` is high at a clock edge while `busy` is low, `pc` equals `callTarget`, `linkReg` equals `retAddr` and `busy` is high from the next cycle on.
- R3: An accepted fast call makes two write transfers. The first goes to address `sp` and carries bits 15:0 of the previous `linkReg`. The second goes to `sp+1` and carries bits 21:16 of that value in bits 5:0, with bits 15:6 zero. `sp` goes up by one on each write acknowledge.
- R4: When `retReq` is high at a clock edge while `busy` is low and `callReq` is low, `pc` takes the value `linkReg` held before that edge, from the next cycle on.
- R5: An accepted fast return makes two read transfers, first from `sp-1` and then from `sp-2`, and `sp` goes down by one on each read acknowledge. On the second acknowledge, `linkReg` becomes bits 5:0 of the first word, placed above the 16 bits of the second word. Bits 15:6 of the first word are ignored.
- R6: A transfer shows `memReq`, `memWe`, `memAddr` and (for writes) `memWdata` and holds them unchanged until the clock edge at which `memAck` is high.
- R7: `busy` stays high from the cycle after a fast call or return is accepted through the cycle in which the second transfer is acknowledged. It is low in the next cycle, and `memReq` is high exactly while `busy` is high.
- R8: `callReq`, `retReq` and `jumpReq` have no effect on `pc`, `linkReg`, `sp` or the memory port while `busy` is high, including in the cycle of the final acknowledge.
- R9: When `jumpReq` is high at a clock edge while idle and neither `callReq` nor `retReq` is high, `pc` takes `jumpTarget`. `linkReg` and `sp` stay unchanged, no transfer starts, and `busy` stays low.
- R10: When several commands arrive together while idle, a fast call wins over a fast return, and a fast return wins over a jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| callReq | input | 1 | Fast call command |
| callTarget | input | 22 | Program counter value for a fast call |
| retAddr | input | 22 | Return address supplied with a fast call |
| retReq | input | 1 | Fast return command |
| jumpReq | input | 1 | Plain jump command, leaves the return register alone |
| jumpTarget | input | 22 | Program counter value for a jump |
| pc | output | 22 | Program counter |
| linkReg | output | 22 | Return address register |
| sp | output | 16 | Stack pointer, in 16-bit words |
| busy | output | 1 | Stack transfers of a fast call or return are in progress |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | High for a write transfer, low for a read |
| memAddr | output | 16 | Word address of the transfer |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memAck on a read |
| memAck | input | 1 | Transfer acknowledge |

## Verification
Two things can happen in the same cycle. The last acknowledge of a spill or refill can coincide with a new command, and call, return and jump requests can all arrive at one idle edge. The bench holds a command high across a whole transfer sequence and drives heavily overlapping random commands with random wait states. This makes both collisions happen many times. A behavioural model with a queue of expected transfers and a word store judges each cycle: it accepts a command only when its queue is empty and picks a winner by call, return, jump order.

// File: rtl/linkspill_pkg.sv
package linkspill_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_POP_HI,
    ST_POP_LO
  } lsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeCall;   // load pc/link for a fast call, latch old link for spill
    logic takeRet;    // load pc from link
    logic takeJump;   // load pc from jump target
    logic xferOn;     // a memory transfer is presented
    logic xferWrite;  // transfer is a push
    logic hiWord;     // transfer carries the upper part of the address
    logic spUp;       // post-increment after an acknowledged push
    logic spDown;     // commit pre-decrement after an acknowledged pop
    logic grabHi;     // hold upper word from the first pop
    logic fillLink;   // rebuild link from both popped words
  } lsCtrl_t;

endpackage

// File: rtl/linkspill_ctrl.sv
module linkspill_ctrl
  import linkspill_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    callReq,
  input  logic    retReq,
  input  logic    jumpReq,
  input  logic    memAck,
  output lsCtrl_t ctrl,
  output logic    busy
);

  lsState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);

  always_comb begin
    ctrl   = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (callReq) begin
          ctrl.takeCall = 1'b1;
          stateD        = ST_PUSH_LO;
        end else if (retReq) begin
          ctrl.takeRet = 1'b1;
          stateD       = ST_POP_HI;
        end else if (jumpReq) begin
          ctrl.takeJump = 1'b1;
        end
      end
      ST_PUSH_LO: begin
        ctrl.xferOn    = 1'b1;
        ctrl.xferWrite = 1'b1;
        if (memAck) begin
          ctrl.spUp = 1'b1;
          stateD    = ST_PUSH_HI;
        end
      end
      ST_PUSH_HI: begin
        ctrl.xferOn    = 1'b1;
        ctrl.xferWrite = 1'b1;
        ctrl.hiWord    = 1'b1;
        if (memAck) begin
          ctrl.spUp = 1'b1;
          stateD    = ST_IDLE;
        end
      end
      ST_POP_HI: begin
        ctrl.xferOn = 1'b1;
        ctrl.hiWord = 1'b1;
        if (memAck) begin
          ctrl.spDown = 1'b1;
          ctrl.grabHi = 1'b1;
          stateD      = ST_POP_LO;
        end
      end
      ST_POP_LO: begin
        ctrl.xferOn = 1'b1;
        if (memAck) begin
          ctrl.spDown   = 1'b1;
          ctrl.fillLink = 1'b1;
          stateD        = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/linkspill_dp.sv
module linkspill_dp
  import linkspill_pkg::*;
#(
  parameter int unsigned ADDR_W   = 22,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned SP_W     = 16,
  parameter logic [ADDR_W-1:0] PC_RST   = '0,
  parameter logic [ADDR_W-1:0] LINK_RST = '0,
  parameter logic [SP_W-1:0]   SP_RST   = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] callTarget,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic [ADDR_W-1:0] jumpTarget,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] linkReg,
  output logic [SP_W-1:0]   sp,
  output logic              memReq,
  output logic              memWe,
  output logic [SP_W-1:0]   memAddr,
  output logic [WORD_W-1:0] memWdata
);

  localparam int unsigned HI_W  = ADDR_W - WORD_W;
  localparam int unsigned PAD_W = WORD_W - HI_W;

  logic [ADDR_W-1:0] pcQ, linkQ, spillQ;
  logic [HI_W-1:0]   hiQ;
  logic [SP_W-1:0]   spQ;
  logic [WORD_W-1:0] hiWordOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ    <= PC_RST;
      linkQ  <= LINK_RST;
      spillQ <= LINK_RST;
      hiQ    <= '0;
      spQ    <= SP_RST;
    end else begin
      if (ctrl.takeCall) begin
        pcQ    <= callTarget;
        linkQ  <= retAddr;
        spillQ <= linkQ;
      end else if (ctrl.takeRet) begin
        pcQ <= linkQ;
      end else if (ctrl.takeJump) begin
        pcQ <= jumpTarget;
      end
      if (ctrl.spUp)        spQ <= spQ + SP_W'(1);
      else if (ctrl.spDown) spQ <= spQ - SP_W'(1);
      if (ctrl.grabHi)   hiQ   <= memRdata[HI_W-1:0];
      if (ctrl.fillLink) linkQ <= {hiQ, memRdata};
    end
  end

  // upper part of the spilled address, zero-extended to a word
  generate
    if (PAD_W == 0) begin : g_noPad
      assign hiWordOut = spillQ[ADDR_W-1:WORD_W];
    end else begin : g_pad
      assign hiWordOut = {{PAD_W{1'b0}}, spillQ[ADDR_W-1:WORD_W]};
    end
  endgenerate

  assign memReq   = ctrl.xferOn;
  assign memWe    = ctrl.xferWrite;
  assign memAddr  = ctrl.xferWrite ? spQ : (spQ - SP_W'(1));
  assign memWdata = ctrl.hiWord ? hiWordOut : spillQ[WORD_W-1:0];

  assign pc      = pcQ;
  assign linkReg = linkQ;
  assign sp      = spQ;

endmodule

// File: rtl/linkspill_unit.sv
module linkspill_unit
  import linkspill_pkg::*;
#(
  parameter int unsigned ADDR_W   = 22,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned SP_W     = 16,
  parameter logic [ADDR_W-1:0] PC_RST   = '0,
  parameter logic [ADDR_W-1:0] LINK_RST = '0,
  parameter logic [SP_W-1:0]   SP_RST   = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              callReq,
  input  logic [ADDR_W-1:0] callTarget,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic              retReq,
  input  logic              jumpReq,
  input  logic [ADDR_W-1:0] jumpTarget,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] linkReg,
  output logic [SP_W-1:0]   sp,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [SP_W-1:0]   memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memAck
);

  lsCtrl_t ctrl;

  linkspill_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .callReq (callReq),
    .retReq  (retReq),
    .jumpReq (jumpReq),
    .memAck  (memAck),
    .ctrl    (ctrl),
    .busy    (busy)
  );

  linkspill_dp #(
    .ADDR_W   (ADDR_W),
    .WORD_W   (WORD_W),
    .SP_W     (SP_W),
    .PC_RST   (PC_RST),
    .LINK_RST (LINK_RST),
    .SP_RST   (SP_RST)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .callTarget (callTarget),
    .retAddr    (retAddr),
    .jumpTarget (jumpTarget),
    .memRdata   (memRdata),
    .pc         (pc),
    .linkReg    (linkReg),
    .sp         (sp),
    .memReq     (memReq),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata)
  );

endmodule

// File: rtl/linkspill_chk.sv
module linkspill_chk #(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SP_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              callReq,
  input logic [ADDR_W-1:0] callTarget,
  input logic [ADDR_W-1:0] retAddr,
  input logic              retReq,
  input logic              jumpReq,
  input logic [ADDR_W-1:0] jumpTarget,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] linkReg,
  input logic [SP_W-1:0]   sp,
  input logic              busy,
  input logic              memReq,
  input logic              memWe,
  input logic [SP_W-1:0]   memAddr,
  input logic [WORD_W-1:0] memWdata,
  input logic              memAck
);

  p_call_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && !busy) |=> (pc == $past(callTarget) && linkReg == $past(retAddr) && busy));

  p_push_sp_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck) |=> (sp == $past(sp) + SP_W'(1)));

  p_ret_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !callReq && !busy) |=> (pc == $past(linkReg) && busy));

  p_pop_sp_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck) |=> (sp == $past(sp) - SP_W'(1)));

  p_xfer_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !callReq && !retReq) |=> (!busy && !memReq));

  p_pc_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(pc));

  p_jump_only_pc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (jumpReq && !callReq && !retReq && !busy) |=>
      (pc == $past(jumpTarget) && $stable(linkReg) && $stable(sp) && !busy));

endmodule

bind linkspill_unit linkspill_chk #(
  .ADDR_W (ADDR_W),
  .WORD_W (WORD_W),
  .SP_W   (SP_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .callReq    (callReq),
  .callTarget (callTarget),
  .retAddr    (retAddr),
  .retReq     (retReq),
  .jumpReq    (jumpReq),
  .jumpTarget (jumpTarget),
  .pc         (pc),
  .linkReg    (linkReg),
  .sp         (sp),
  .busy       (busy),
  .memReq     (memReq),
  .memWe      (memWe),
  .memAddr    (memAddr),
  .memWdata   (memWdata),
  .memAck     (memAck)
);

// File: tb/linkspill_unit_tb_top.sv
`timescale 1ns/1ps
module linkspill_unit_tb_top;

  localparam logic [21:0] PC_RST   = 22'h000040;
  localparam logic [21:0] LINK_RST = 22'h2ABCDE;
  localparam logic [15:0] SP_RST   = 16'h0100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        callReq = 1'b0, retReq = 1'b0, jumpReq = 1'b0;
  logic [21:0] callTarget = '0, retAddr = '0, jumpTarget = '0;
  logic [21:0] pc, linkReg;
  logic [15:0] sp, memAddr, memWdata;
  logic [15:0] memRdata = '0;
  logic        busy, memReq, memWe;
  logic        memAck = 1'b0;

  always #2.5 clk = ~clk;

  linkspill_unit #(
    .PC_RST   (PC_RST),
    .LINK_RST (LINK_RST),
    .SP_RST   (SP_RST)
  ) dut_i (
    .clk(clk), .rstN(rstN),
    .callReq(callReq), .callTarget(callTarget), .retAddr(retAddr),
    .retReq(retReq), .jumpReq(jumpReq), .jumpTarget(jumpTarget),
    .pc(pc), .linkReg(linkReg), .sp(sp), .busy(busy),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // ---------------- reference model ----------------
  typedef struct {
    bit          we;
    bit          hi;
    logic [15:0] addr;
    logic [15:0] data;
  } xfer_t;

  xfer_t       q[$];
  logic [15:0] store [int];
  logic [21:0] expPc, expLink;
  logic [15:0] expSp;
  logic [5:0]  hiHold;

  function automatic logic [15:0] wordAt(logic [15:0] a);
    if (store.exists(int'(a))) return store[int'(a)];
    return {a[7:0] ^ 8'hA5, a[15:8] ^ 8'h3C};
  endfunction

  always @(posedge clk) begin
    xfer_t t;
    logic [15:0] rd;
    if (!rstN) begin
      expPc   = PC_RST;
      expLink = LINK_RST;
      expSp   = SP_RST;
      hiHold  = '0;
      q.delete();
    end else if (q.size() != 0) begin
      if (memAck) begin
        t = q.pop_front();
        if (t.we) begin
          store[int'(t.addr)] = t.data;
          expSp = expSp + 16'd1;
        end else begin
          rd    = wordAt(t.addr);
          expSp = expSp - 16'd1;
          if (t.hi) hiHold = rd[5:0];
          else      expLink = {hiHold, rd};
        end
      end
    end else if (callReq) begin
      t.we = 1'b1; t.hi = 1'b0; t.addr = expSp; t.data = expLink[15:0];
      q.push_back(t);
      t.hi = 1'b1; t.addr = expSp + 16'd1; t.data = {10'd0, expLink[21:16]};
      q.push_back(t);
      expLink = retAddr;
      expPc   = callTarget;
    end else if (retReq) begin
      t.we = 1'b0; t.hi = 1'b1; t.addr = expSp - 16'd1; t.data = '0;
      q.push_back(t);
      t.hi = 1'b0; t.addr = expSp - 16'd2;
      q.push_back(t);
      expPc = expLink;
    end else if (jumpReq) begin
      expPc = jumpTarget;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R2 R4 R8 R9 R10 pc", 32'(pc), 32'(expPc));
    chk("R2 R5 R8 linkReg", 32'(linkReg), 32'(expLink));
    chk("R3 R5 sp", 32'(sp), 32'(expSp));
    chk("R7 busy", 32'(busy), 32'(q.size() != 0));
    chk("R7 memReq", 32'(memReq), 32'(q.size() != 0));
    if (q.size() != 0) begin
      chk("R3 R5 memWe", 32'(memWe), 32'(q[0].we));
      chk("R3 R5 R6 memAddr", 32'(memAddr), 32'(q[0].addr));
      if (q[0].we) chk("R3 R6 memWdata", 32'(memWdata), 32'(q[0].data));
    end
  endtask

  // one cycle: compare settled outputs, then drive the next inputs
  task automatic step(input bit c, input bit r, input bit j, input int ackPct);
    @(negedge clk);
    compareAll();
    callReq    = c;
    retReq     = r;
    jumpReq    = j;
    callTarget = 22'($urandom);
    retAddr    = 22'($urandom);
    jumpTarget = 22'($urandom);
    memAck     = (q.size() != 0) && ($urandom_range(0, 99) < ackPct);
    memRdata   = (q.size() != 0 && !q[0].we) ? wordAt(q[0].addr) : 16'h0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values observed while reset is held
    chk("R1 pc reset", 32'(pc), 32'(PC_RST));
    chk("R1 linkReg reset", 32'(linkReg), 32'(LINK_RST));
    chk("R1 sp reset", 32'(sp), 32'(SP_RST));
    chk("R1 busy reset", 32'(busy), 32'd0);
    chk("R1 memReq reset", 32'(memReq), 32'd0);
    rstN = 1'b1;
    step(0, 0, 0, 100);
    // R1: still at reset values after release
    chk("R1 pc after release", 32'(pc), 32'(PC_RST));
    // R5: return refills from unwritten words whose upper bits are nonzero
    step(0, 1, 0, 100);
    repeat (6) step(0, 0, 0, 50);
    // R8: call held high through a whole spill, incl. final acknowledge cycle
    repeat (14) step(1, 0, 0, 60);
    // R8: return held high
    repeat (14) step(0, 1, 0, 60);
    // R10: all three together, then return with jump
    step(1, 1, 1, 100);
    repeat (6) step(0, 0, 0, 100);
    step(0, 1, 1, 100);
    repeat (6) step(0, 0, 0, 100);
    // R9: plain jumps back to back
    repeat (4) step(0, 0, 1, 100);
    // R6 R7: long wait states, then random overlapping traffic
    step(1, 0, 0, 0);
    repeat (8) step(0, 0, 0, 10);
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 9);
      step(r < 3, r >= 2 && r <= 5, r >= 5 && r <= 6, 45);
    end
    repeat (20) step(0, 0, 0, 100);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule